// File: doc/BRIEF.md
# Dual-Core Peripheral Interrupt Router

This block sits between 112 peripheral interrupt lines and the interrupt controllers of two processor cores. Every source has its own routing register. Its two low bits act as a per-core enable mask, so a source can be delivered to core 0, to core 1, to both, or to neither. The gated result is registered once, so each core sees its interrupt vector exactly one clock after the input.

Software reaches the block over a small register bus with 16-bit data. A window-select input chooses between two windows. One is the router window, which holds the routing registers. The other is the configuration window, which holds a read-only core-number register. A master-ID input names the core that makes each access, and the core-number register returns that ID. Each core can therefore find out which core it is.

The routing registers read back exactly as written. Software can save the whole routing table before a power-down and write it back afterwards.

Top module: `irq_router_top`

## Requirements
- R1: There are 112 sources, numbered 0 to 111. The routing register for source n sits at byte offset 0x80 + 2*n of the router window (`win_sel`=0). A read returns the core-enable field in bits [1:0], exactly as it was last written, whatever the master ID.
- R2: Bit 0 of routing register n gates source n to `core0_irq[n]`, and bit 1 gates it to `core1_irq[n]`. Setting both bits delivers the source to both cores. The value of `coreK_irq[n]` after a clock edge equals `irq_in[n]` AND enable bit K, both sampled at that edge.
- R3: Writing zero to a routing register stops that source from reaching either core. This holds even while its input is asserted.
- R4: Bits [15:2] of every read response are zero. Routing-register bits [15:2] ignore writes.
- R5: A read of byte offset 0x4 in the configuration window (`win_sel`=1) returns `req_mid` zero-extended: 0 when core 0 reads and 1 when core 1 reads. Writes to the configuration window have no effect.
- R6: After reset, every routing register reads zero and both output vectors are zero, even with every input asserted.
- R7: An access to an odd, unmapped or out-of-range address completes normally. A read returns zero, and a write changes no routing register.
- R8: `req_ready` is always high, so every request is accepted in the cycle it is presented. A read raises `rsp_valid` with `rsp_rdata` in the following cycle. A write raises no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always high) |
| req_we | input | 1 | 1 = write, 0 = read |
| win_sel | input | 1 | 0 = router window, 1 = configuration window |
| req_addr | input | 11 | Byte offset within the selected window |
| req_wdata | input | 16 | Write data |
| req_mid | input | 1 | ID of the accessing core |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 16 | Read data |
| irq_in | input | 112 | Peripheral interrupt inputs |
| core0_irq | output | 112 | Interrupts delivered to core 0 |
| core1_irq | output | 112 | Interrupts delivered to core 1 |

## Verification
A corrupted enable bit shows up on the output vector of its core one clock after the matching input is raised. It also shows up in the read-back of that routing register on the following response. Random interrupt patterns are therefore applied after every routing change, so a stale or misdecoded entry is exposed within a few cycles.

A decode fault is a different case. A write that lands on the wrong index, or a reserved bit that gets stored, stays hidden until some later read or interrupt touches the entry that was hit. Full-table sweeps after the unmapped writes and after the save/restore pass expose such faults.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_SRC    = 112;
  localparam int NUM_CORE   = 2;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 11;
  localparam int ROUTE_BASE = 'h80;
  localparam int CPUNUM_OFS = 'h4;

  // True when addr falls on a routing register of a table with nsrc entries.
  function automatic logic route_hit(input logic [ADDR_W-1:0] addr, input int nsrc);
    int a;
    a = int'(addr);
    return (addr[0] == 1'b0) && (a >= ROUTE_BASE) && (a < ROUTE_BASE + 2 * nsrc);
  endfunction

  // Source index of a routing register address (valid only when route_hit).
  function automatic int route_idx(input logic [ADDR_W-1:0] addr);
    return (int'(addr) - ROUTE_BASE) / 2;
  endfunction
endpackage

// File: rtl/irq_route_bus.sv
module irq_route_bus
  import irq_route_pkg::*;
#(
  parameter int NSRC  = NUM_SRC,
  parameter int AW    = ADDR_W,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             win_sel,
  input  logic [AW-1:0]    req_addr,
  output logic             wr_stb,
  output logic             rd_route,
  output logic             rd_cpunum,
  output logic [IDX_W-1:0] acc_idx
);
  logic hit;
  int   idx_i;

  always_comb begin
    hit       = !win_sel && route_hit(req_addr, NSRC);
    idx_i     = hit ? route_idx(req_addr) : 0;
    acc_idx   = IDX_W'(idx_i);
    wr_stb    = req_valid && req_we && hit;
    rd_route  = req_valid && !req_we && hit;
    rd_cpunum = req_valid && !req_we && win_sel && (int'(req_addr) == CPUNUM_OFS);
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NSRC  = 112,
  parameter int NCORE = 2,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic [NCORE-1:0]      wr_bits,
  output logic [NCORE-1:0]      rd_bits,
  output logic [NCORE*NSRC-1:0] en_flat
);
  logic [NCORE-1:0] en_q [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NSRC; n++) en_q[n] <= '0;
    end else if (wr_stb) begin
      en_q[acc_idx] <= wr_bits;
    end
  end

  assign rd_bits = (int'(acc_idx) < NSRC) ? en_q[acc_idx] : '0;

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    for (genvar n = 0; n < NSRC; n++) begin : g_src
      assign en_flat[k*NSRC+n] = en_q[n][k];
    end
  end
endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate #(
  parameter int NSRC = 112
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] en_col,
  output logic [NSRC-1:0] irq_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= irq_in & en_col;
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_route_pkg::*;
#(
  parameter int NSRC  = NUM_SRC,
  parameter int NCORE = NUM_CORE,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int MID_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_we,
  input  logic            win_sel,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [MID_W-1:0] req_mid,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  input  logic [NSRC-1:0] irq_in,
  output logic [NSRC-1:0] core0_irq,
  output logic [NSRC-1:0] core1_irq
);
  localparam int IDX_W = $clog2(NSRC);

  logic                  wr_stb, rd_route, rd_cpunum;
  logic [IDX_W-1:0]      acc_idx;
  logic [NCORE-1:0]      rd_bits;
  logic [NCORE*NSRC-1:0] en_flat;
  logic [NSRC-1:0]       core_irq [NCORE];

  assign req_ready = 1'b1;

  irq_route_bus #(.NSRC(NSRC), .AW(AW), .IDX_W(IDX_W)) u_bus (
    .req_valid(req_valid), .req_we(req_we), .win_sel(win_sel), .req_addr(req_addr),
    .wr_stb(wr_stb), .rd_route(rd_route), .rd_cpunum(rd_cpunum), .acc_idx(acc_idx)
  );

  irq_route_regs #(.NSRC(NSRC), .NCORE(NCORE), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .acc_idx(acc_idx),
    .wr_bits(req_wdata[NCORE-1:0]), .rd_bits(rd_bits), .en_flat(en_flat)
  );

  for (genvar k = 0; k < NCORE; k++) begin : g_gate
    irq_route_gate #(.NSRC(NSRC)) u_gate (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .en_col(en_flat[k*NSRC +: NSRC]), .irq_out(core_irq[k])
    );
  end

  assign core0_irq = core_irq[0];
  assign core1_irq = core_irq[NCORE-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_we;
      if (rd_route)       rsp_rdata <= DW'(rd_bits);
      else if (rd_cpunum) rsp_rdata <= DW'(req_mid);
      else                rsp_rdata <= '0;
    end
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NSRC  = 112,
  parameter int NCORE = 2,
  parameter int DW    = 16,
  parameter int AW    = 11,
  parameter int MID_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_we,
  input logic             win_sel,
  input logic [AW-1:0]    req_addr,
  input logic [MID_W-1:0] req_mid,
  input logic             rsp_valid,
  input logic [DW-1:0]    rsp_rdata,
  input logic [NSRC-1:0]  irq_in,
  input logic [NSRC-1:0]  core0_irq,
  input logic [NSRC-1:0]  core1_irq,
  input logic             wr_stb
);
  logic is_rd, mapped, cfg_num;
  assign is_rd   = req_valid && !req_we;
  assign mapped  = !win_sel && !req_addr[0] && (req_addr >= AW'('h80))
                   && (req_addr <= AW'('h80 + 2 * (NSRC - 1)));
  assign cfg_num = win_sel && (req_addr == AW'(4));

  a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rsp_valid);
  a_r8_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rsp_valid);
  a_r5_cpu_number: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && cfg_num) |=> (rsp_rdata == DW'($past(req_mid))));
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DW-1:NCORE] == '0));
  a_r7_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !mapped && !cfg_num) |=> (rsp_rdata == '0));
  a_r7_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && !mapped) |-> !wr_stb);
  a_r2_core0_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((core0_irq & ~$past(irq_in)) == '0));
  a_r2_core1_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((core1_irq & ~$past(irq_in)) == '0));
endmodule

bind irq_router_top irq_route_chk #(
  .NSRC(NSRC), .NCORE(NCORE), .DW(DW), .AW(AW), .MID_W(MID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .win_sel(win_sel), .req_addr(req_addr), .req_mid(req_mid),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_in(irq_in),
  .core0_irq(core0_irq), .core1_irq(core1_irq), .wr_stb(wr_stb)
);

// File: tb/sim_irq_router_top.sv
module sim_irq_router_top;
  localparam int CLK_P = 10;
  localparam int NS    = 112;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0, win_sel = 1'b0, req_mid = 1'b0;
  logic [10:0]   req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [NS-1:0] irq_in = '0;
  logic [NS-1:0] core0_irq, core1_irq;

  int checks = 0;
  int errors = 0;
  logic [1:0] model [NS];
  logic [1:0] saved [NS];

  always #(CLK_P/2) clk = ~clk;

  irq_router_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .win_sel(win_sel), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mid(req_mid), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_in(irq_in), .core0_irq(core0_irq), .core1_irq(core1_irq)
  );

  function automatic logic [NS-1:0] expect_core(input int k, input logic [NS-1:0] v);
    logic [NS-1:0] r;
    for (int n = 0; n < NS; n++) r[n] = v[n] & model[n][k];
    return r;
  endfunction

  function automatic logic [NS-1:0] rnd_vec();
    return NS'({$urandom, $urandom, $urandom, $urandom});
  endfunction

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic w, input logic [10:0] a, input logic [15:0] d, input logic m);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; win_sel = w; req_addr = a; req_wdata = d; req_mid = m;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    if (!rsp_valid) checks++;
    else begin checks++; errors++; $display("FAIL R8 write gave response actual=1 expected=0"); end
  endtask

  task automatic bus_rd(input logic w, input logic [10:0] a, input logic m, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; win_sel = w; req_addr = a; req_mid = m;
    checks++;
    if (req_ready !== 1'b1) begin errors++; $display("FAIL R8 ready actual=%b expected=1", req_ready); end
    @(negedge clk);
    req_valid = 1'b0;
    chk16("R8 rsp_valid", {15'd0, rsp_valid}, 16'd1);
    d = rsp_rdata;
  endtask

  task automatic irq_chk(input string tag, input logic [NS-1:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
    chkv({tag, " core0"}, core0_irq, expect_core(0, v));
    chkv({tag, " core1"}, core1_irq, expect_core(1, v));
  endtask

  task automatic sweep(input string tag);
    logic [15:0] d;
    for (int n = 0; n < NS; n++) begin
      bus_rd(1'b0, 11'(16'h80 + 2 * n), n[0], d);
      chk16(tag, d, {14'd0, model[n]});
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1234));
    for (int n = 0; n < NS; n++) model[n] = 2'b00;
    irq_in = '1;
    repeat (3) @(negedge clk);
    chkv("R6 reset core0", core0_irq, '0);
    chkv("R6 reset core1", core1_irq, '0);
    rst_n = 1'b1;
    irq_chk("R6 after reset all inputs high", '1);
    bus_rd(1'b0, 11'h80, 1'b0, d);  chk16("R6 reg0 reset", d, 16'd0);
    bus_rd(1'b0, 11'h15E, 1'b1, d); chk16("R6 reg111 reset", d, 16'd0);

    // R5 core number
    bus_rd(1'b1, 11'h004, 1'b0, d); chk16("R5 cpu number core0", d, 16'd0);
    bus_rd(1'b1, 11'h004, 1'b1, d); chk16("R5 cpu number core1", d, 16'd1);
    bus_wr(1'b1, 11'h004, 16'hFFFF, 1'b0);
    bus_rd(1'b1, 11'h004, 1'b0, d); chk16("R5 cpu number after write", d, 16'd0);

    // R2 directed per-bit routing, R4 reserved bits
    bus_wr(1'b0, 11'h80, 16'hFFFD, 1'b0); model[0] = 2'b01;
    bus_wr(1'b0, 11'h82, 16'hABCE, 1'b1); model[1] = 2'b10;
    bus_wr(1'b0, 11'h15E, 16'h0003, 1'b0); model[111] = 2'b11;
    bus_rd(1'b0, 11'h80, 1'b1, d);  chk16("R4 reserved bits reg0", d, 16'h0001);
    bus_rd(1'b0, 11'h82, 1'b0, d);  chk16("R4 reserved bits reg1", d, 16'h0002);
    bus_rd(1'b0, 11'h15E, 1'b1, d); chk16("R1 reg111 readback", d, 16'h0003);
    irq_chk("R2 directed bits", '1);

    // R3 zero blocks an asserted source
    bus_wr(1'b0, 11'h15E, 16'h0000, 1'b1); model[111] = 2'b00;
    irq_chk("R3 zero blocks", '1);

    // R7 unmapped reads and writes
    bus_wr(1'b0, 11'h81, 16'h0003, 1'b0);
    bus_wr(1'b0, 11'h160, 16'h0003, 1'b0);
    bus_wr(1'b0, 11'h7E, 16'h0003, 1'b1);
    bus_wr(1'b0, 11'h004, 16'h0003, 1'b0);
    bus_wr(1'b1, 11'h080, 16'h0003, 1'b1);
    bus_rd(1'b0, 11'h83, 1'b0, d);  chk16("R7 odd read", d, 16'd0);
    bus_rd(1'b0, 11'h160, 1'b0, d); chk16("R7 past end read", d, 16'd0);
    bus_rd(1'b0, 11'h7FF, 1'b1, d); chk16("R7 top read", d, 16'd0);
    bus_rd(1'b1, 11'h006, 1'b1, d); chk16("R7 config unmapped read", d, 16'd0);
    sweep("R7 table unchanged");

    // Random routing and interrupt patterns
    for (int i = 0; i < 400; i++) begin
      int idx;
      logic [15:0] v;
      idx = int'($urandom % NS);
      v = 16'($urandom);
      bus_wr(1'b0, 11'(16'h80 + 2 * idx), v, 1'($urandom));
      model[idx] = v[1:0];
      irq_chk("R2 random", rnd_vec());
      if (i % 4 == 0) begin
        idx = int'($urandom % NS);
        bus_rd(1'b0, 11'(16'h80 + 2 * idx), 1'($urandom), d);
        chk16("R1 random readback", d, {14'd0, model[idx]});
      end
    end

    // R1 save, clear, restore
    for (int n = 0; n < NS; n++) begin
      bus_rd(1'b0, 11'(16'h80 + 2 * n), 1'b0, d);
      saved[n] = d[1:0];
      chk16("R1 save", d, {14'd0, model[n]});
    end
    for (int n = 0; n < NS; n++) begin
      bus_wr(1'b0, 11'(16'h80 + 2 * n), 16'h0000, 1'b1);
      model[n] = 2'b00;
    end
    irq_chk("R3 all cleared", '1);
    for (int n = 0; n < NS; n++) begin
      bus_wr(1'b0, 11'(16'h80 + 2 * n), {14'd0, saved[n]}, 1'b0);
      model[n] = saved[n];
    end
    sweep("R1 restored");
    irq_chk("R2 after restore", rnd_vec());
    irq_chk("R2 after restore all high", '1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule